// File: doc/BRIEF.md
# External Interrupt Sense and Arbitration

This block is the external-interrupt front end of a small microcontroller. It watches one non-maskable pin and four maskable request pins, named IRQ0, IRQ1, IRQ4 and IRQ5. Every pin passes through a two-stage synchroniser before detection. Each maskable pin has its own sense stage, which detects either a low level or a falling edge. The sense stage sets a status flag, and only software can clear that flag. The request that a flag raises is gated by an enable bit, and each source has a priority bit that places it at one of two levels.

A combinational arbiter picks one request each cycle and gives the CPU a valid line and a vector number. A pending non-maskable event always wins. A CPU-side global mask blocks the maskable sources but never the non-maskable one. A separate wake output tells the power controller that a source allowed to end standby is pending. A small write/read register port holds the sense modes, enables, priorities and flags.

Top module: `ext_irq_front`

## Requirements
- R1: A pending non-maskable event always drives reqValid=1 with reqVector=7, whatever cpuMask and the maskable flags hold.
- R2: Bit 7 of register 0 selects the non-maskable polarity: 1 takes a rising edge of the synchronised pin, 0 a falling edge. An edge of the other polarity is ignored.
- R3: A cycle with cpuAck=1 clears the pending non-maskable event.
- R4: Bits 3:0 of register 0 pick the sense mode of IRQ0, IRQ1, IRQ4 and IRQ5 (bit 0 is IRQ0, bit 1 is IRQ1, bit 2 is IRQ4, bit 3 is IRQ5). 1 means falling edge, and each 1-to-0 transition sets the flag once. 0 means low level, and the flag is set on every cycle the synchronised pin is low. A pin change made between edges is visible in the flag after the third rising clock edge.
- R5: Register 2 reads the four flags in the same bit order. Writing 0 to a bit clears that flag and writing 1 has no effect. Flags are set whatever the enable bits hold.
- R6: Register 1 holds the enables. A maskable source requests only when its flag and its enable bit are both 1.
- R7: When a set condition and a software clear hit the same flag in the same cycle, the flag stays set.
- R8: cpuMask=1 removes every maskable request from reqValid.
- R9: Register 3 holds the priority bits. An enabled pending source with priority 1 beats any source with priority 0. Among equals the lower IRQ number wins. The vectors are IRQ0=12, IRQ1=13, IRQ4=16 and IRQ5=17.
- R10: wakeOut is 1 while the non-maskable event is pending, or while IRQ0 or IRQ1 is both flagged and enabled. cpuMask does not affect it, and IRQ4 and IRQ5 never raise it.
- R11: After reset every register and flag is 0 and reqValid and wakeOut are 0. Registers 0, 1 and 3 read back the values written to them, and unused bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| wrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Register select |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for regAddr |
| nmiPin | input | 1 | Non-maskable request pin |
| irqPin | input | 4 | Maskable pins: IRQ0, IRQ1, IRQ4, IRQ5 from bit 0 up |
| cpuMask | input | 1 | CPU global mask for maskable sources |
| cpuAck | input | 1 | CPU acknowledge of the non-maskable request |
| reqValid | output | 1 | An interrupt is being requested |
| reqVector | output | 6 | Vector number of the winning request |
| wakeOut | output | 1 | Standby exit request |

## Verification
A software clear of a flag can fall in the same cycle as that flag's set condition. The bench provokes this by holding a pin low in level mode while writing 0 to its status bit. It then reads the flag back through the status register and expects it to be 1. It also repeats the clear with the pin held low in edge mode, where the flag must read 0 because no new edge has occurred. Randomised rounds mix enables, priorities, the mask and pin patterns. Each round is judged against a bench function that applies the priority, tie-break and vector rules.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
  localparam int NUM_SRC  = 4;
  localparam int VEC_W    = 6;
  localparam int NMI_VEC  = 7;
  localparam int VEC_BASE = 12;
  localparam int GAP_AT   = 2;
  localparam int GAP      = 2;
  localparam logic [NUM_SRC-1:0] WAKE_MASK = 4'b0011;
  localparam logic [1:0] SENSE_ADDR = 2'd0;
  localparam logic [1:0] ENA_ADDR   = 2'd1;
  localparam logic [1:0] STAT_ADDR  = 2'd2;
  localparam logic [1:0] PRIO_ADDR  = 2'd3;

  typedef struct packed {
    logic [NUM_SRC-1:0] flagClr;
    logic               nmiClr;
  } ctrlStrobe_t;

  function automatic logic [VEC_W-1:0] srcVector(input int idx);
    int v;
    v = VEC_BASE + idx;
    if (idx >= GAP_AT) v = v + GAP;
    return v[VEC_W-1:0];
  endfunction
endpackage

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
  import ext_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  logic               cpuAck,
  input  logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] senseEdge,
  output logic [NUM_SRC-1:0] enable,
  output logic [NUM_SRC-1:0] prio,
  output logic               nmiRise,
  output ctrlStrobe_t        strobe,
  output logic [DATA_W-1:0]  rdData
);
  logic unusedBits;
  assign unusedBits = ^wrData[DATA_W-2:NUM_SRC];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      senseEdge <= '0;
      enable    <= '0;
      prio      <= '0;
      nmiRise   <= 1'b0;
    end else if (wrEn) begin
      case (regAddr)
        SENSE_ADDR: begin
          senseEdge <= wrData[NUM_SRC-1:0];
          nmiRise   <= wrData[DATA_W-1];
        end
        ENA_ADDR:  enable <= wrData[NUM_SRC-1:0];
        PRIO_ADDR: prio   <= wrData[NUM_SRC-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    strobe.flagClr = (wrEn && regAddr == STAT_ADDR) ? ~wrData[NUM_SRC-1:0] : '0;
    strobe.nmiClr  = cpuAck;
  end

  always_comb begin
    rdData = '0;
    case (regAddr)
      SENSE_ADDR: begin
        rdData[NUM_SRC-1:0] = senseEdge;
        rdData[DATA_W-1]    = nmiRise;
      end
      ENA_ADDR:  rdData[NUM_SRC-1:0] = enable;
      STAT_ADDR: rdData[NUM_SRC-1:0] = flags;
      default:   rdData[NUM_SRC-1:0] = prio;
    endcase
  end
endmodule

// File: rtl/ext_irq_datapath.sv
module ext_irq_datapath
  import ext_irq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               nmiPin,
  input  logic [NUM_SRC-1:0] irqPin,
  input  logic [NUM_SRC-1:0] senseEdge,
  input  logic               nmiRise,
  input  ctrlStrobe_t        strobe,
  output logic [NUM_SRC-1:0] flags,
  output logic [NUM_SRC-1:0] irqSet,
  output logic               nmiPending
);
  localparam int PIPE_W = SYNC_STAGES + 1;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    logic [PIPE_W-1:0] pipe;
    logic syncNow, syncPrev;
    assign syncNow  = pipe[SYNC_STAGES-1];
    assign syncPrev = pipe[SYNC_STAGES];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) pipe <= '1;
      else       pipe <= {pipe[PIPE_W-2:0], irqPin[i]};
    end

    assign irqSet[i] = senseEdge[i] ? (syncPrev & ~syncNow) : ~syncNow;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) flags[i] <= 1'b0;
      else       flags[i] <= irqSet[i] | (flags[i] & ~strobe.flagClr[i]);
    end
  end

  logic [PIPE_W-1:0] nmiPipe;
  logic nmiEdge;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPipe <= '0;
    else       nmiPipe <= {nmiPipe[PIPE_W-2:0], nmiPin};
  end

  assign nmiEdge = nmiRise ? (~nmiPipe[SYNC_STAGES] & nmiPipe[SYNC_STAGES-1])
                           : (nmiPipe[SYNC_STAGES] & ~nmiPipe[SYNC_STAGES-1]);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) nmiPending <= 1'b0;
    else       nmiPending <= nmiEdge | (nmiPending & ~strobe.nmiClr);
  end
endmodule

// File: rtl/ext_irq_arbiter.sv
module ext_irq_arbiter
  import ext_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] enable,
  input  logic [NUM_SRC-1:0] prio,
  input  logic               cpuMask,
  input  logic               nmiPending,
  output logic               reqValid,
  output logic [VEC_W-1:0]   reqVector,
  output logic               wakeOut
);
  logic [NUM_SRC-1:0] cand, hiCand, pool;
  int pickIdx;

  assign cand   = flags & enable & {NUM_SRC{~cpuMask}};
  assign hiCand = cand & prio;
  assign pool   = (|hiCand) ? hiCand : cand;

  always_comb begin
    pickIdx = 0;
    for (int i = NUM_SRC - 1; i >= 0; i--)
      if (pool[i]) pickIdx = i;
  end

  always_comb begin
    if (nmiPending) begin
      reqValid  = 1'b1;
      reqVector = VEC_W'(NMI_VEC);
    end else begin
      reqValid  = |cand;
      reqVector = (|cand) ? srcVector(pickIdx) : '0;
    end
  end

  assign wakeOut = nmiPending | (|(flags & enable & WAKE_MASK));
endmodule

// File: rtl/ext_irq_front.sv
module ext_irq_front
  import ext_irq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic              nmiPin,
  input  logic [3:0]        irqPin,
  input  logic              cpuMask,
  input  logic              cpuAck,
  output logic              reqValid,
  output logic [5:0]        reqVector,
  output logic              wakeOut
);
  ctrlStrobe_t        strobe;
  logic [NUM_SRC-1:0] senseEdge, enable, prio, flags, irqSet;
  logic               nmiRise, nmiPending;

  ext_irq_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .cpuAck(cpuAck), .flags(flags), .senseEdge(senseEdge), .enable(enable),
    .prio(prio), .nmiRise(nmiRise), .strobe(strobe), .rdData(rdData)
  );

  ext_irq_datapath u_dp (
    .clk(clk), .rstN(rstN), .nmiPin(nmiPin), .irqPin(irqPin),
    .senseEdge(senseEdge), .nmiRise(nmiRise), .strobe(strobe),
    .flags(flags), .irqSet(irqSet), .nmiPending(nmiPending)
  );

  ext_irq_arbiter u_arb (
    .flags(flags), .enable(enable), .prio(prio), .cpuMask(cpuMask),
    .nmiPending(nmiPending), .reqValid(reqValid), .reqVector(reqVector),
    .wakeOut(wakeOut)
  );
endmodule

// File: rtl/ext_irq_checker.sv
module ext_irq_checker
  import ext_irq_pkg::*;
(
  input logic               clk,
  input logic               rstN,
  input logic               wrEn,
  input logic [1:0]         regAddr,
  input logic               cpuMask,
  input logic               reqValid,
  input logic [5:0]         reqVector,
  input logic               wakeOut,
  input logic               nmiPending,
  input logic [NUM_SRC-1:0] flags,
  input logic [NUM_SRC-1:0] enable,
  input logic [NUM_SRC-1:0] irqSet
);
  p_nmi_first_r1: assert property (@(posedge clk) disable iff (!rstN)
    nmiPending |-> (reqValid && reqVector == 6'd7));

  p_clear_only_by_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(flags) & ~flags)) |-> $past(wrEn && regAddr == STAT_ADDR));

  p_req_needs_enable_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !nmiPending) |-> (|(flags & enable)));

  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    (|irqSet) |=> ((flags & $past(irqSet)) == $past(irqSet)));

  p_mask_blocks_r8: assert property (@(posedge clk) disable iff (!rstN)
    (cpuMask && !nmiPending) |-> !reqValid);

  p_vector_legal_r9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |-> (reqVector == 6'd7 || reqVector == 6'd12 || reqVector == 6'd13 ||
                  reqVector == 6'd16 || reqVector == 6'd17));

  p_wake_source_r10: assert property (@(posedge clk) disable iff (!rstN)
    wakeOut |-> (nmiPending || (|(flags[1:0] & enable[1:0]))));
endmodule

bind ext_irq_front ext_irq_checker u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .cpuMask(cpuMask),
  .reqValid(reqValid), .reqVector(reqVector), .wakeOut(wakeOut),
  .nmiPending(nmiPending), .flags(flags), .enable(enable), .irqSet(irqSet)
);

// File: tb/sim_ext_irq_front.sv
`timescale 1ns/1ps
module sim_ext_irq_front;
  logic clk = 1'b0, rstN = 1'b0, wrEn = 1'b0, nmiPin = 1'b1, cpuMask = 1'b0, cpuAck = 1'b0;
  logic [1:0] regAddr = '0;
  logic [7:0] wrData = '0;
  logic [3:0] irqPin = 4'hF;
  logic [7:0] rdData;
  logic reqValid, wakeOut;
  logic [5:0] reqVector;
  int total = 0, bad = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  ext_irq_front u0 (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .regAddr(regAddr), .wrData(wrData),
    .rdData(rdData), .nmiPin(nmiPin), .irqPin(irqPin), .cpuMask(cpuMask),
    .cpuAck(cpuAck), .reqValid(reqValid), .reqVector(reqVector), .wakeOut(wakeOut)
  );

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(int a, int d);
    @(negedge clk);
    wrEn = 1'b1; regAddr = 2'(a); wrData = 8'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(int a, output int d);
    regAddr = 2'(a);
    #0.5;
    d = int'(rdData);
  endtask

  // Expected vector from the priority and tie rules; -1 means no request.
  function automatic int expVec(bit [3:0] f, bit [3:0] en, bit [3:0] pr, bit m);
    int vt[4] = '{12, 13, 16, 17};
    bit [3:0] c, h;
    c = f & en & {4{~m}};
    h = c & pr;
    if (h != 0) c = h;
    for (int i = 0; i < 4; i++) if (c[i]) return vt[i];
    return -1;
  endfunction

  initial begin
    int v;
    void'($urandom(32'd4242));
    cyc(3);
    rstN = 1'b1;
    cyc(3);
    // R11 reset state
    chk("R11 reqValid after reset", reqValid, 0);
    chk("R11 wakeOut after reset", wakeOut, 0);
    rd(2, v); chk("R11 flags after reset", v, 0);
    rd(0, v); chk("R11 sense after reset", v, 0);

    // R5/R6: flag set with enable off, then enable gates the request
    irqPin[2] = 1'b0; cyc(1); irqPin[2] = 1'b1; cyc(4);
    rd(2, v); chk("R5 flag set while disabled", v, 4);
    chk("R6 no request when disabled", reqValid, 0);
    wr(1, 4'b0100);
    chk("R6 request once enabled", reqValid, 1);
    chk("R9 IRQ4 vector", reqVector, 16);
    chk("R10 IRQ4 never wakes", wakeOut, 0);
    wr(2, 8'hFF);
    rd(2, v); chk("R5 writing 1 has no effect", v, 4);
    wr(2, 8'hFB);
    rd(2, v); chk("R5 writing 0 clears", v, 0);
    rd(1, v); chk("R11 enable readback", v, 4);

    // R4 edge mode and latency on IRQ1
    wr(0, 8'h02); wr(1, 8'h02);
    irqPin[1] = 1'b0;
    cyc(2); chk("R4 no flag after two edges", reqValid, 0);
    cyc(1); chk("R4 flag after third edge", reqValid, 1);
    chk("R9 IRQ1 vector", reqVector, 13);
    chk("R10 IRQ1 wakes", wakeOut, 1);
    wr(2, 8'hFD); cyc(3);
    rd(2, v); chk("R4 edge mode sets once", v, 0);
    irqPin[1] = 1'b1; cyc(3);

    // R7 set beats clear in level mode
    wr(0, 8'h00);
    irqPin[1] = 1'b0; cyc(4);
    wr(2, 8'hFD);
    rd(2, v); chk("R7 set wins over clear", v, 2);
    irqPin[1] = 1'b1; cyc(3);
    wr(2, 8'hFD);
    rd(2, v); chk("R4 level flag clears after release", v, 0);

    // R9 priority and tie-break, R8 mask, R10 wake under mask
    wr(1, 4'hF);
    irqPin = 4'b0110; cyc(4); irqPin = 4'hF; cyc(3);
    chk("R9 tie goes to lower IRQ", reqVector, 12);
    wr(3, 8'h08);
    chk("R9 priority 1 wins", reqVector, 17);
    rd(3, v); chk("R11 priority readback", v, 8);
    cpuMask = 1'b1; #0.5;
    chk("R8 mask blocks maskable", reqValid, 0);
    chk("R10 wake ignores mask", wakeOut, 1);
    wr(2, 8'h00); wr(3, 8'h00);
    chk("R10 wake drops after clear", wakeOut, 0);

    // R1/R2/R3 non-maskable path, mask still set
    nmiPin = 1'b0; cyc(3);
    chk("R1 NMI taken under mask", reqValid, 1);
    chk("R1 NMI vector", reqVector, 7);
    chk("R10 NMI wakes", wakeOut, 1);
    cpuAck = 1'b1; cyc(1); cpuAck = 1'b0;
    chk("R3 ack clears NMI", reqValid, 0);
    wr(0, 8'h80);
    rd(0, v); chk("R11 polarity bit readback", v, 128);
    nmiPin = 1'b1; cyc(3);
    chk("R2 rising edge in rising mode", reqVector, 7);
    cpuAck = 1'b1; cyc(1); cpuAck = 1'b0;
    nmiPin = 1'b0; cyc(4);
    chk("R2 falling edge ignored in rising mode", reqValid, 0);
    cpuMask = 1'b0;

    // Randomised rounds
    for (int r = 0; r < 40; r++) begin
      bit [3:0] en, pr, pat;
      bit m;
      int ev;
      en = 4'($urandom); pr = 4'($urandom); pat = 4'($urandom); m = 1'($urandom);
      wr(0, 8'h80); wr(1, en); wr(3, pr);
      cpuMask = m;
      irqPin = ~pat; cyc(3); irqPin = 4'hF; cyc(3);
      rd(2, v); chk("R5 random flags", v, pat);
      ev = expVec(pat, en, pr, m);
      chk("R6 R8 random reqValid", reqValid, (ev >= 0) ? 1 : 0);
      if (ev >= 0) chk("R9 random vector", reqVector, ev);
      chk("R10 random wake", wakeOut, ((pat & en & 4'b0011) != 0) ? 1 : 0);
      wr(2, 8'h00);
      rd(2, v); chk("R5 random clear", v, 0);
    end
    cpuMask = 1'b0;

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule